// File: doc/BRIEF.md
# Exception Cause Priority Selector

This block takes a 16-bit vector of pending trap causes, one bit per cause number, and returns the single cause that wins under a fixed architectural priority. The result is a 4-bit cause code plus a valid flag. The priority is not numeric. A breakpoint wins first. Instruction-side faults follow, then environment calls from the highest privilege down. Store faults are ranked ahead of the matching load faults.

A 2-bit selection input limits which causes a source may raise. It chooses one of three masks: a built-in mask for the instruction front end, a built-in mask of every implemented cause, or a mask supplied by the source itself. Cause numbers 10 and 14 are not implemented and are always dropped.

The selector is purely combinational. It computes the cause, but the trap address, status-register updates and pipeline flush are done elsewhere.

Top module: `exc_cause_pick`

## Requirements
- R1: `maskMode` selects the mask: 0 is the front-end preset, 1 is the all-implemented preset, 2 is the external `srcMask`, and 3 lets no cause through.
- R2: In mode 0, only cause bits 0, 1, 2 and 12 can be reported. Every other bit of `excVec` is ignored.
- R3: In mode 1, cause bits 0 to 9, 11, 12, 13 and 15 can be reported.
- R4: In mode 2, a cause can be reported only when its bit is set in both `excVec` and `srcMask`, and the cause is implemented.
- R5: Cause codes 10 and 14 are never reported in any mode. A vector holding only those bits gives `causeValid` = 0.
- R6: When several allowed causes are pending, the reported code is the first of them in this order: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R7: `causeValid` is 1 exactly when at least one bit of `excVec` survives the selected mask and the implemented set.
- R8: While `causeValid` is 0, `causeCode` is 0.
- R9: Outputs depend only on the present inputs, with no stored state. A new input value is reflected in the same cycle.
- R10: In mode 3, `causeValid` is 0 for any `excVec` and `srcMask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| excVec | input | 16 | Pending causes, bit n is cause number n |
| srcMask | input | 16 | Source-supplied mask, used in mode 2 |
| maskMode | input | 2 | Mask selection (0 front end, 1 all, 2 external, 3 none) |
| causeValid | output | 1 | At least one allowed cause is pending |
| causeCode | output | 4 | Winning cause number, 0 when not valid |

## Verification
Both outputs are due zero cycles after a stimulus, because no register lies between the inputs and the outputs. The driver applies each stimulus just after a rising edge and pushes the expected pair, computed from a separate priority table and separate mask constants. The monitor pops that pair at the following falling edge, after the inputs have settled and before the next stimulus arrives. This keeps every comparison inside the same cycle as the stimulus it belongs to.

// File: rtl/excSelPkg.sv
`timescale 1ns/1ps
package excSelPkg;
  localparam int VEC_W    = 16;
  localparam int CODE_W   = $clog2(VEC_W);
  localparam int NUM_RANK = 14;

  // implemented causes: 0-9, 11, 12, 13, 15
  localparam logic [VEC_W-1:0] IMPL_MASK  = 16'hBBFF;
  // front-end causes: 0, 1, 2, 12
  localparam logic [VEC_W-1:0] FRONT_MASK = 16'h1007;

  typedef enum logic [1:0] {
    SEL_FRONT = 2'd0,
    SEL_ALL   = 2'd1,
    SEL_EXT   = 2'd2,
    SEL_NONE  = 2'd3
  } selMode_e;

  // strobes from mask control to the priority datapath
  typedef struct packed {
    logic [VEC_W-1:0] passMask;
    logic             anyOpen;
  } ctrlStrb_t;

  // rank 0 is the most urgent cause
  function automatic logic [CODE_W-1:0] rankCause(input int rank);
    case (rank)
      0:  rankCause = CODE_W'(3);
      1:  rankCause = CODE_W'(12);
      2:  rankCause = CODE_W'(1);
      3:  rankCause = CODE_W'(2);
      4:  rankCause = CODE_W'(0);
      5:  rankCause = CODE_W'(11);
      6:  rankCause = CODE_W'(9);
      7:  rankCause = CODE_W'(8);
      8:  rankCause = CODE_W'(6);
      9:  rankCause = CODE_W'(4);
      10: rankCause = CODE_W'(15);
      11: rankCause = CODE_W'(13);
      12: rankCause = CODE_W'(7);
      default: rankCause = CODE_W'(5);
    endcase
  endfunction
endpackage

// File: rtl/excMaskCtrl.sv
`timescale 1ns/1ps
module excMaskCtrl
  import excSelPkg::*;
#(
  parameter int VEC_W_P = VEC_W
) (
  input  logic [VEC_W_P-1:0] srcMask,
  input  logic [1:0]         maskMode,
  output ctrlStrb_t          ctrlStrb
);
  logic [VEC_W_P-1:0] modeMask;

  always_comb begin
    case (selMode_e'(maskMode))
      SEL_FRONT: modeMask = FRONT_MASK;
      SEL_ALL:   modeMask = IMPL_MASK;
      SEL_EXT:   modeMask = srcMask;
      default:   modeMask = '0;
    endcase
  end

  // unimplemented causes are dropped in every mode (R5)
  assign ctrlStrb.passMask = modeMask & IMPL_MASK;
  assign ctrlStrb.anyOpen  = |ctrlStrb.passMask;
endmodule

// File: rtl/excPrioPath.sv
`timescale 1ns/1ps
module excPrioPath
  import excSelPkg::*;
#(
  parameter int VEC_W_P  = VEC_W,
  parameter int NUM_RANK_P = NUM_RANK,
  localparam int CODE_W_L = $clog2(VEC_W_P)
) (
  input  logic [VEC_W_P-1:0]  excVec,
  input  ctrlStrb_t           ctrlStrb,
  output logic                causeValid,
  output logic [CODE_W_L-1:0] causeCode
);
  logic [VEC_W_P-1:0]    survivors;
  logic [NUM_RANK_P-1:0] rankHit;

  assign survivors = excVec & ctrlStrb.passMask;

  // one hit line per priority rank
  for (genvar r = 0; r < NUM_RANK_P; r++) begin : gRank
    assign rankHit[r] = survivors[rankCause(r)];
  end

  always_comb begin
    causeCode = '0;
    // walk from least to most urgent so the most urgent overrides (R6)
    for (int r = NUM_RANK_P - 1; r >= 0; r--) begin
      if (rankHit[r]) causeCode = CODE_W_L'(rankCause(r));
    end
  end

  assign causeValid = ctrlStrb.anyOpen & (|rankHit);
endmodule

// File: rtl/exc_cause_pick.sv
`timescale 1ns/1ps
module exc_cause_pick
  import excSelPkg::*;
(
  input  logic [15:0] excVec,
  input  logic [15:0] srcMask,
  input  logic [1:0]  maskMode,
  output logic        causeValid,
  output logic [3:0]  causeCode
);
  ctrlStrb_t ctrlStrb;

  excMaskCtrl #(.VEC_W_P(VEC_W)) uCtrl (
    .srcMask  (srcMask),
    .maskMode (maskMode),
    .ctrlStrb (ctrlStrb)
  );

  excPrioPath #(.VEC_W_P(VEC_W), .NUM_RANK_P(NUM_RANK)) uPath (
    .excVec     (excVec),
    .ctrlStrb   (ctrlStrb),
    .causeValid (causeValid),
    .causeCode  (causeCode)
  );
endmodule

// File: rtl/excSelChk.sv
`timescale 1ns/1ps
module excSelChk (
  input logic [15:0] excVec,
  input logic [15:0] srcMask,
  input logic [1:0]  maskMode,
  input logic        causeValid,
  input logic [3:0]  causeCode
);
  logic [15:0] allowed;

  always_comb begin
    case (maskMode)
      2'd0:    allowed = excVec & 16'h1007;
      2'd1:    allowed = excVec & 16'hBBFF;
      2'd2:    allowed = excVec & srcMask & 16'hBBFF;
      default: allowed = 16'h0000;
    endcase
  end

  always_comb begin
    assert_valid_match_R7: assert (causeValid == (allowed != 16'h0000))
      else $error("valid flag mismatch");
    if (!causeValid)
      assert_idle_zero_R8: assert (causeCode == 4'd0)
        else $error("code not zero while idle");
    if (causeValid)
      assert_code_pending_R4: assert (allowed[causeCode])
        else $error("reported cause not allowed or not pending");
    if (causeValid)
      assert_no_unused_R5: assert (causeCode != 4'd10 && causeCode != 4'd14)
        else $error("unused cause reported");
    if (maskMode == 2'd3)
      assert_none_mode_R10: assert (!causeValid)
        else $error("valid in none mode");
    if (allowed[3])
      assert_break_first_R6: assert (causeValid && causeCode == 4'd3)
        else $error("breakpoint not first");
  end
endmodule

bind exc_cause_pick excSelChk uChk (.*);

// File: tb/tb_exc_cause_pick.sv
`timescale 1ns/1ps
module tb_exc_cause_pick;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [15:0] excVec = '0;
  logic [15:0] srcMask = '0;
  logic [1:0]  maskMode = '0;
  logic        causeValid;
  logic [3:0]  causeCode;

  exc_cause_pick dut (
    .excVec(excVec), .srcMask(srcMask), .maskMode(maskMode),
    .causeValid(causeValid), .causeCode(causeCode)
  );

  typedef struct {
    logic       v;
    logic [3:0] c;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int prioList[14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

  function automatic expItem_t refModel(input logic [15:0] vec, input logic [15:0] msk,
                                        input logic [1:0] mode);
    expItem_t e;
    logic [15:0] keep;
    case (mode)
      2'd0: keep = 16'b0001_0000_0000_0111;
      2'd1: keep = 16'b1011_1011_1111_1111;
      2'd2: keep = msk & 16'b1011_1011_1111_1111;
      default: keep = 16'h0;
    endcase
    keep = keep & vec;
    e.v = 1'b0;
    e.c = 4'd0;
    for (int i = 0; i < 14; i++) begin
      if (!e.v && keep[prioList[i]]) begin
        e.v = 1'b1;
        e.c = 4'(prioList[i]);
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [15:0] vec, input logic [15:0] msk,
                       input logic [1:0] mode, input string tag);
    expItem_t e;
    @(posedge clk);
    #1;
    excVec = vec;
    srcMask = msk;
    maskMode = mode;
    e = refModel(vec, msk, mode);
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  // monitor: outputs are due in the same cycle, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        total++;
        if (causeValid !== e.v || causeCode !== e.c) begin
          bad++;
          $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
                   e.tag, causeValid, causeCode, e.v, e.c);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] lfsr2;
    // idle state: nothing pending (R7, R8)
    drive(16'h0000, 16'h0000, 2'd1, "R8 idle");
    // everything pending, all mode: breakpoint wins (R6, R3)
    drive(16'hFFFF, 16'h0000, 2'd1, "R6 all pending");
    // only unused bits (R5)
    drive(16'h4400, 16'h0000, 2'd1, "R5 unused only all-mode");
    drive(16'h4400, 16'hFFFF, 2'd2, "R5 unused only ext-mode");
    // front-end preset (R2, R1)
    drive(16'hFFFF, 16'h0000, 2'd0, "R2 front all pending");
    drive(16'h0009, 16'h0000, 2'd0, "R2 front drops breakpoint");
    drive(16'hEFF8, 16'h0000, 2'd0, "R2 front none allowed");
    // all preset covers the late causes (R3)
    drive(16'h8000, 16'h0000, 2'd1, "R3 cause 15 alone");
    drive(16'h2000, 16'h0000, 2'd1, "R3 cause 13 alone");
    // external masks (R4)
    drive(16'hFFFF, 16'h2030, 2'd2, "R4 load source");
    drive(16'h8080, 16'h80C0, 2'd2, "R4 store source");
    drive(16'h0B04, 16'h0B0C, 2'd2, "R4 system source");
    drive(16'h0020, 16'h0010, 2'd2, "R4 masked off");
    // none mode (R10, R1)
    drive(16'hFFFF, 16'hFFFF, 2'd3, "R10 none mode");
    // priority walk: each rank against all lower ranks (R6)
    for (int r = 0; r < 14; r++) begin
      logic [15:0] v;
      v = '0;
      for (int k = r; k < 14; k++) v[prioList[k]] = 1'b1;
      drive(v, 16'h0000, 2'd1, "R6 priority walk");
    end
    // back-to-back changing inputs, same-cycle response (R9)
    lfsr = 16'hACE1;
    lfsr2 = 16'h1D2B;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lfsr2 = {lfsr2[14:0], lfsr2[15] ^ lfsr2[13] ^ lfsr2[12] ^ lfsr2[10]};
      drive(lfsr & (i[0] ? 16'hFFFF : 16'h50A3), lfsr2, 2'(i % 4), "R9 sweep");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule